// File: doc/BRIEF.md
# Parallel Smart-Panel Write Controller

This block writes to a display module that keeps its own frame memory, over a write-only 8080-style parallel bus. The host presents one tagged word at a time. The tag marks the word as a command index or as data. When the block is idle it accepts the word. It then splits the word into one, two or three bus beats, formatted for the selected pin width and pixel mode. For each word it drives an active-low chip select, a register-select line and an active-low write strobe, with the beat value on the data pins.

The bus mode sets how a command index is laid out: 8-bit, 9-bit, 16-bit or 18-bit pins. The pixel mode sets how a data word is laid out. The low and high phases of the strobe can each be set to a number of clocks. The block samples the modes and the phase lengths when it accepts a word, so the host may change them while a transfer runs. The `busy` output stays high from acceptance until chip select is released. Any word presented while `busy` is high is dropped.

Top module: `panel_wr_ctrl`

## Requirements
- R1: While reset is low, and on the first clock after it, the outputs are `cs_n`=1, `wr_n`=1, `rs`=0, `db`=0 and `busy`=0. Reset in the middle of a transfer abandons the beats that are left.
- R2: A word is accepted at a clock edge where `in_valid` is 1 and `busy` is 0. `in_valid` asserted while `busy` is 1 has no effect on the outputs. `bus_mode`, `pix_mode`, `lo_clks` and `hi_clks` are sampled only at acceptance.
- R3: `rs` is 0 on every beat of a command word (`in_cmd`=1) and 1 on every beat of a data word. It is constant from chip-select assertion until release.
- R4: After acceptance, chip select falls on the next clock. It is held for one clock with `wr_n` high before the first strobe. Each beat then has `wr_n` low for max(`lo_clks`,1) clocks and high for max(`hi_clks`,1) clocks. Chip select stays low for one more clock after the last high phase. `busy` equals the inverse of `cs_n`.
- R5: A command on bus mode 0 (8-bit) or 1 (9-bit) takes two beats on `db[7:0]`: index bits 15:8 first, then bits 7:0.
- R6: A command on bus mode 2 (16-bit) takes one beat with `db[15:0]` = index.
- R7: A command on bus mode 3 (18-bit) takes one beat with `db[17:10]` = index[15:8] and `db[8:1]` = index[7:0]. Pins 9 and 0 are 0.
- R8: Data in pixel mode 0 is one beat of `in_word[7:0]`. Mode 1 is two beats: bits 15:8, then 7:0. Mode 2 is three beats: bits 23:16, then 15:8, then 7:0. All of these go out on `db[7:0]`.
- R9: Data in pixel mode 3 is two 9-bit beats on `db[8:0]`: `in_word[17:9]`, then `in_word[8:0]`.
- R10: Data in pixel mode 4 is one beat with `db[15:0]` = `in_word[15:0]`. Mode 5 is one beat with `db[17:0]` = `in_word[17:0]`.
- R11: Data in pixel modes 6 and 7 is one beat of `in_word[15:0]`, remapped onto the 18 pins in the same way as R7.
- R12: Pins above the width of a beat are 0. `db` holds each beat through its low and high phases, and through the release clock for the last beat. `db` is 0 while chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_mode | input | 2 | Pin width for commands: 0=8, 1=9, 2=16, 3=18 |
| pix_mode | input | 3 | Data beat layout, 0..7 as in R8 to R11 |
| lo_clks | input | TW | Strobe low phase in clocks (0 acts as 1) |
| hi_clks | input | TW | Strobe high phase in clocks (0 acts as 1) |
| in_valid | input | 1 | Host presents a word |
| in_cmd | input | 1 | 1 = command index, 0 = data |
| in_word | input | 24 | Word value |
| cs_n | output | 1 | Panel chip select, active low |
| rs | output | 1 | Register select, 0 = command, 1 = data |
| wr_n | output | 1 | Write strobe, active low |
| db | output | 18 | Data pins |
| busy | output | 1 | Transfer in flight |

## Verification
The hardest case to reach from the ports is a word arriving while a transfer runs. It comes with different modes, phase lengths and tag, and must not leak into the current beats or start a second transfer. The stimulus holds `in_valid` high with altered settings through every cycle of selected transfers and drops it only in the release cycle. Back-to-back words are issued on the first idle cycle, so both the acceptance edge and the drop of held words are exercised. A reset applied in the middle of a three-beat word checks that the remaining beats are abandoned.

// File: rtl/panel_wr_ctrl.sv
module panel_wr_ctrl #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    bus_mode,
  input  logic [2:0]    pix_mode,
  input  logic [TW-1:0] lo_clks,
  input  logic [TW-1:0] hi_clks,
  input  logic          in_valid,
  input  logic          in_cmd,
  input  logic [23:0]   in_word,
  output logic          cs_n,
  output logic          rs,
  output logic          wr_n,
  output logic [17:0]   db,
  output logic          busy
);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_LOW, S_HIGH, S_HOLD} st_t;

  st_t           st;
  logic [23:0]   w_q;
  logic          cmd_q;
  logic [1:0]    bus_q;
  logic [2:0]    pix_q;
  logic [TW-1:0] lo_q, hi_q, cnt;
  logic [1:0]    idx, last;
  logic [17:0]   beat;

  wire [TW-1:0] lo_m1 = (lo_q == '0) ? '0 : lo_q - 1'b1;
  wire [TW-1:0] hi_m1 = (hi_q == '0) ? '0 : hi_q - 1'b1;
  wire [17:0]   remap = {w_q[15:8], 1'b0, w_q[7:0], 1'b0};

  always_comb begin
    last = 2'd0;
    if (cmd_q) begin
      if (bus_q == 2'd0 || bus_q == 2'd1) last = 2'd1;
    end else begin
      case (pix_q)
        3'd1, 3'd3: last = 2'd1;
        3'd2:       last = 2'd2;
        default:    last = 2'd0;
      endcase
    end
  end

  always_comb begin
    beat = '0;
    if (cmd_q) begin
      case (bus_q)
        2'd0, 2'd1: beat[7:0] = (idx == 2'd0) ? w_q[15:8] : w_q[7:0];
        2'd2:       beat[15:0] = w_q[15:0];
        default:    beat = remap;
      endcase
    end else begin
      case (pix_q)
        3'd0: beat[7:0] = w_q[7:0];
        3'd1: beat[7:0] = (idx == 2'd0) ? w_q[15:8] : w_q[7:0];
        3'd2: beat[7:0] = (idx == 2'd0) ? w_q[23:16] :
                          (idx == 2'd1) ? w_q[15:8] : w_q[7:0];
        3'd3: beat[8:0] = (idx == 2'd0) ? w_q[17:9] : w_q[8:0];
        3'd4: beat[15:0] = w_q[15:0];
        3'd5: beat = w_q[17:0];
        default: beat = remap;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      w_q   <= '0;
      cmd_q <= 1'b0;
      bus_q <= '0;
      pix_q <= '0;
      lo_q  <= '0;
      hi_q  <= '0;
      cnt   <= '0;
      idx   <= '0;
    end else begin
      case (st)
        S_IDLE: if (in_valid) begin
          w_q   <= in_word;
          cmd_q <= in_cmd;
          bus_q <= bus_mode;
          pix_q <= pix_mode;
          lo_q  <= lo_clks;
          hi_q  <= hi_clks;
          idx   <= '0;
          st    <= S_SETUP;
        end
        S_SETUP: begin
          cnt <= lo_m1;
          st  <= S_LOW;
        end
        S_LOW: begin
          if (cnt == '0) begin
            cnt <= hi_m1;
            st  <= S_HIGH;
          end else cnt <= cnt - 1'b1;
        end
        S_HIGH: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else if (idx == last) st <= S_HOLD;
          else begin
            idx <= idx + 1'b1;
            cnt <= lo_m1;
            st  <= S_LOW;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign cs_n = (st == S_IDLE);
  assign busy = (st != S_IDLE);
  assign wr_n = (st != S_LOW);
  assign rs   = (st != S_IDLE) && !cmd_q;
  assign db   = (st == S_IDLE) ? '0 : beat;

endmodule

module panel_wr_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cs_n,
  input logic        rs,
  input logic        wr_n,
  input logic [17:0] db,
  input logic        busy
);

  p_strobe_in_select_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> !cs_n);

  p_setup_clock_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> (wr_n && busy));

  p_release_after_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> $past(wr_n));

  p_rs_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(!cs_n)) |-> $stable(rs));

  p_beat_held_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n) |-> ($stable(db) && $stable(rs)));

  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (wr_n && !rs && !busy && db == '0));

endmodule

bind panel_wr_ctrl panel_wr_ctrl_chk u_chk (.*);

// File: tb/panel_wr_ctrl_tb.sv
module panel_wr_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_mode = '0;
  logic [2:0]  pix_mode = '0;
  logic [3:0]  lo_clks = '0;
  logic [3:0]  hi_clks = '0;
  logic        in_valid = 1'b0;
  logic        in_cmd = 1'b0;
  logic [23:0] in_word = '0;
  logic        cs_n, rs, wr_n, busy;
  logic [17:0] db;

  always #4 clk = ~clk;

  panel_wr_ctrl #(.TW(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_mode(bus_mode), .pix_mode(pix_mode),
    .lo_clks(lo_clks), .hi_clks(hi_clks), .in_valid(in_valid),
    .in_cmd(in_cmd), .in_word(in_word), .cs_n(cs_n), .rs(rs),
    .wr_n(wr_n), .db(db), .busy(busy)
  );

  typedef struct packed {
    logic        cs_n;
    logic        wr_n;
    logic        rs;
    logic        busy;
    logic [17:0] db;
  } frm_t;

  frm_t  expq[$];
  string tagq[$];
  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 1'b0;

  task automatic tick(input string idle_tag);
    frm_t e;
    string t;
    @(negedge clk);
    if (expq.size() > 0) begin
      e = expq.pop_front();
      t = tagq.pop_front();
    end else begin
      e = '{1'b1, 1'b1, 1'b0, 1'b0, 18'd0};
      t = idle_tag;
    end
    n_chk++;
    if ({cs_n, wr_n, rs, busy, db} !== e) begin
      n_fail++;
      $display("FAIL %s: cs_n wr_n rs busy db actual %b %b %b %b %h expected %b %b %b %b %h",
               t, cs_n, wr_n, rs, busy, db, e.cs_n, e.wr_n, e.rs, e.busy, e.db);
    end
  endtask

  function automatic void beats(input bit cmd, input logic [23:0] w,
                                input logic [1:0] bm, input logic [2:0] pm,
                                ref logic [17:0] q[$]);
    logic [17:0] rm;
    rm = 18'd0;
    rm[17:10] = w[15:8];
    rm[8:1]   = w[7:0];
    q.delete();
    if (cmd) begin
      if (bm <= 2'd1) begin
        q.push_back({10'd0, w[15:8]});
        q.push_back({10'd0, w[7:0]});
      end else if (bm == 2'd2) q.push_back({2'd0, w[15:0]});
      else q.push_back(rm);
    end else begin
      case (pm)
        3'd0: q.push_back({10'd0, w[7:0]});
        3'd1: begin q.push_back({10'd0, w[15:8]}); q.push_back({10'd0, w[7:0]}); end
        3'd2: begin
          q.push_back({10'd0, w[23:16]});
          q.push_back({10'd0, w[15:8]});
          q.push_back({10'd0, w[7:0]});
        end
        3'd3: begin q.push_back({9'd0, w[17:9]}); q.push_back({9'd0, w[8:0]}); end
        3'd4: q.push_back({2'd0, w[15:0]});
        3'd5: q.push_back(w[17:0]);
        default: q.push_back(rm);
      endcase
    end
  endfunction

  task automatic start(input bit cmd, input logic [23:0] w, input logic [1:0] bm,
                       input logic [2:0] pm, input int lo, input int hi, input string tag);
    logic [17:0] bq[$];
    int L, H;
    logic r;
    L = (lo == 0) ? 1 : lo;
    H = (hi == 0) ? 1 : hi;
    r = !cmd;
    in_cmd = cmd; in_word = w; bus_mode = bm; pix_mode = pm;
    lo_clks = 4'(lo); hi_clks = 4'(hi); in_valid = 1'b1;
    beats(cmd, w, bm, pm, bq);
    expq.push_back('{1'b0, 1'b1, r, 1'b1, bq[0]}); tagq.push_back(tag);
    foreach (bq[k]) begin
      for (int i = 0; i < L; i++) begin expq.push_back('{1'b0, 1'b0, r, 1'b1, bq[k]}); tagq.push_back(tag); end
      for (int i = 0; i < H; i++) begin expq.push_back('{1'b0, 1'b1, r, 1'b1, bq[k]}); tagq.push_back(tag); end
    end
    expq.push_back('{1'b0, 1'b1, r, 1'b1, bq[bq.size()-1]}); tagq.push_back(tag);
  endtask

  task automatic send(input bit cmd, input logic [23:0] w, input logic [1:0] bm,
                      input logic [2:0] pm, input int lo, input int hi,
                      input bit poke, input string tag);
    start(cmd, w, bm, pm, lo, hi, tag);
    tick("R2");
    in_valid = poke;
    if (poke) begin
      in_cmd = ~cmd; in_word = 24'h5A5A5A; bus_mode = ~bm; pix_mode = ~pm;
      lo_clks = 4'd7; hi_clks = 4'd9;
    end
    while (expq.size() > 0) tick("R2");
    in_valid = 1'b0;
    tick("R2");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset state, even with a word offered
    in_valid = 1'b1; in_word = 24'hFFFFFF;
    repeat (3) tick("R1");
    in_valid = 1'b0;
    rst_n = 1'b1;
    tick("R1");

    // R5 R6 R7: command layouts per bus mode
    send(1'b1, 24'h000202, 2'd0, 3'd0, 1, 1, 1'b0, "R5 R3 R4");
    send(1'b1, 24'h00A55A, 2'd1, 3'd5, 2, 3, 1'b0, "R5 R4 R12");
    send(1'b1, 24'h001234, 2'd2, 3'd0, 0, 0, 1'b0, "R6 R4");
    send(1'b1, 24'h00FFFF, 2'd3, 3'd4, 1, 2, 1'b0, "R7 R12");
    send(1'b1, 24'hFF0281, 2'd3, 3'd0, 3, 1, 1'b1, "R7 R2");

    // R8 to R11: data layouts per pixel mode
    send(1'b0, 24'hABCDEF, 2'd3, 3'd0, 1, 1, 1'b0, "R8 R12 R3");
    send(1'b0, 24'hABCDEF, 2'd0, 3'd1, 2, 1, 1'b0, "R8");
    send(1'b0, 24'hABCDEF, 2'd1, 3'd2, 1, 2, 1'b1, "R8 R2");
    send(1'b0, 24'h02A1FF, 2'd1, 3'd3, 1, 1, 1'b0, "R9");
    send(1'b0, 24'hFD5E00, 2'd2, 3'd3, 0, 2, 1'b1, "R9 R2");
    send(1'b0, 24'hFFFFFF, 2'd2, 3'd4, 1, 1, 1'b0, "R10 R12");
    send(1'b0, 24'hFFFFFF, 2'd3, 3'd5, 2, 2, 1'b0, "R10");
    send(1'b0, 24'h12C35A, 2'd3, 3'd6, 1, 1, 1'b0, "R11");
    send(1'b0, 24'h00FF00, 2'd0, 3'd7, 4, 4, 1'b1, "R11 R2");

    // R1: reset in the middle of a three-beat word
    start(1'b0, 24'h112233, 2'd0, 3'd2, 2, 2, "R1 R8");
    tick("R2");
    in_valid = 1'b0;
    repeat (4) tick("R2");
    rst_n = 1'b0;
    expq.delete(); tagq.delete();
    tick("R1");
    rst_n = 1'b1;
    repeat (2) tick("R1");
    send(1'b1, 24'h000200, 2'd2, 3'd0, 1, 1, 1'b0, "R1 R6");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule